// File: doc/BRIEF.md
# Read-to-Write Turnaround Scheduler

This block sits on the controller side of a burst-of-two DDR SRAM. It accepts a stream of read and write requests over a valid/ready handshake and turns each accepted request into one registered command: an active-low load strobe, a read/write select and an address. When the bus changes from read to write, the memory needs idle cycles between the two commands. The scheduler enforces that gap and adds no spacing anywhere else.

The gap is two idle cycles, or three when `cfg_extra_idle` is high. Cycles in which the requester offers nothing count toward the gap, so a stream that is already sparse is never slowed. While a write must wait, `req_ready` stays low. The requester keeps `req_valid`, `req_write` and `req_addr` steady until the handshake completes, and the write then goes out unchanged.

Back-pressure rules: a transfer happens on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops only while a write is offered inside a read-to-write window, so reads are never held back. `cfg_extra_idle` is meant to change only while no read-to-write window is open.

Top module: `sram_turn_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ld_n` is 1, `cmd_rd` is 1, `cmd_addr` is 0 and `req_ready` is 1.
- R2: A request accepted at a rising edge appears in the next cycle as `cmd_ld_n`=0, with `cmd_rd`=1 for a read (`req_write`=0) or `cmd_rd`=0 for a write (`req_write`=1), and `cmd_addr` equal to the accepted address.
- R3: Reads offered on consecutive cycles are all accepted and issued on consecutive cycles.
- R4: Writes offered on consecutive cycles are issued on consecutive cycles, and a read that follows a write is issued in the very next cycle.
- R5: With `cfg_extra_idle`=0, at least two idle cycles (`cmd_ld_n`=1) separate a read command from a later write command, and a waiting write goes out after exactly two.
- R6: With `cfg_extra_idle`=1, the read-to-write gap is at least three idle cycles, and a waiting write goes out after exactly three.
- R7: Idle cycles in the request stream (`req_valid`=0) after a read count toward the gap. A write offered once the gap has passed is accepted at once.
- R8: `req_ready` is low only when `req_valid` and `req_write` are both high inside a read-to-write window. A write that was held back is issued with its original address.
- R9: In a cycle with no accepted request, the next cycle shows `cmd_ld_n`=1, and `cmd_addr` and `cmd_rd` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_extra_idle | input | 1 | 0: two turnaround idles, 1: three |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | Request can be taken this cycle |
| cmd_ld_n | output | 1 | Active-low command load strobe |
| cmd_rd | output | 1 | 1 = read command, 0 = write command |
| cmd_addr | output | ADDR_W | Command address |

## Verification
A wrong "last command was a read" flag shows in the cycle it first matters. Either a write leaves right after a read with too few idles, or `req_ready` drops during a write-only or write-to-read stream. A miscounted idle counter moves the first strobe of a waiting write by one cycle, and the bench compares every output on every clock against its own model, so that cycle is caught. A command register that fails to hold shows up as a changed address or select in the first idle cycle after a command.

// File: rtl/sram_turn_pkg.sv
package sram_turn_pkg;
  // Turnaround idles needed after a read, base and with the extra idle
  localparam int unsigned BASE_IDLES  = 2;
  localparam int unsigned EXTRA_IDLES = 1;
  localparam int unsigned MAX_IDLES   = BASE_IDLES + EXTRA_IDLES;
  localparam int unsigned IDLE_CNT_W  = $clog2(MAX_IDLES + 1);

  typedef logic [IDLE_CNT_W-1:0] idle_cnt_t;

  function automatic idle_cnt_t needed_idles(input logic extra);
    needed_idles = extra ? idle_cnt_t'(MAX_IDLES) : idle_cnt_t'(BASE_IDLES);
  endfunction
endpackage

// File: rtl/turn_gap_tracker.sv
module turn_gap_tracker
  import sram_turn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_extra_idle,
  input  logic fire,
  input  logic fire_write,
  output logic write_ok
);
  logic      last_was_rd;
  idle_cnt_t idles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_was_rd <= 1'b0;
      idles       <= idle_cnt_t'(MAX_IDLES);
    end else if (fire) begin
      last_was_rd <= ~fire_write;
      idles       <= '0;
    end else if (idles != idle_cnt_t'(MAX_IDLES)) begin
      idles <= idles + 1'b1;
    end
  end

  assign write_ok = !last_was_rd || (idles >= needed_idles(cfg_extra_idle));

  // R4: after a write command, the next write is never held back
  a_r4_write_stream_free: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_write) |=> write_ok);

  // R3: a read leaves the window closed for writes on the next cycle
  a_r3_read_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !fire_write) |=> !write_ok);
endmodule

// File: rtl/turn_cmd_reg.sv
module turn_cmd_reg #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              fire_write,
  input  logic [ADDR_W-1:0] fire_addr,
  output logic              ld_n,
  output logic              rd,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_n <= 1'b1;
      rd   <= 1'b1;
      addr <= '0;
    end else if (fire) begin
      ld_n <= 1'b0;
      rd   <= ~fire_write;
      addr <= fire_addr;
    end else begin
      ld_n <= 1'b1;
    end
  end

  // R2: accepted request becomes a command in the following cycle
  a_r2_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!ld_n && addr == $past(fire_addr) && rd == !$past(fire_write)));

  // R9: idle cycle keeps strobe high, address and select held
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (ld_n && $stable(addr) && $stable(rd)));
endmodule

// File: rtl/sram_turn_sched.sv
module sram_turn_sched
  import sram_turn_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_extra_idle,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              cmd_ld_n,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic write_ok;
  logic fire;

  assign req_ready = !(req_valid && req_write && !write_ok);
  assign fire      = req_valid && req_ready;

  turn_gap_tracker u_gap (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_extra_idle (cfg_extra_idle),
    .fire           (fire),
    .fire_write     (req_write),
    .write_ok       (write_ok)
  );

  turn_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .fire_write (req_write),
    .fire_addr  (req_addr),
    .ld_n       (cmd_ld_n),
    .rd         (cmd_rd),
    .addr       (cmd_addr)
  );

  logic rd_cmd, wr_cmd;
  assign rd_cmd = !cmd_ld_n && cmd_rd;
  assign wr_cmd = !cmd_ld_n && !cmd_rd;

  // R5: two idles between a read command and a write command
  a_r5_two_idles: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |-> (!$past(rd_cmd) && !$past(rd_cmd, 2)));

  // R6: third idle when the extra-idle option is set
  a_r6_three_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cfg_extra_idle) |-> !$past(rd_cmd, 3));

  // R8: back-pressure only against an offered write
  a_r8_ready_low_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (req_valid && req_write));

  // R8: a stalled request stays offered unchanged by rule; it then leaves intact
  a_r8_stall_then_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> cmd_ld_n);
endmodule

// File: tb/sram_turn_sched_test.sv
`timescale 1ns/1ps
module sram_turn_sched_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_extra_idle = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic          cmd_ld_n;
  logic          cmd_rd;
  logic [AW-1:0] cmd_addr;

  always #4 clk = ~clk;

  sram_turn_sched #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_extra_idle(cfg_extra_idle),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .cmd_ld_n(cmd_ld_n), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr)
  );

  int tests = 0;
  int fails = 0;

  // behavioural model
  bit            m_last_rd = 0;
  int            m_idles = 3;
  bit            e_ld_n = 1;
  bit            e_rd = 1;
  logic [AW-1:0] e_addr = '0;
  bit            e_ready;
  int            obs_gap = 99;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check ready mid-cycle, update model at edge,
  // check registered outputs at the following negedge
  task automatic cyc(input bit v, input bit w, input logic [AW-1:0] a, input string tag);
    int need;
    req_valid = v; req_write = w; req_addr = a;
    #1;
    need = cfg_extra_idle ? 3 : 2;
    e_ready = !(v && w && m_last_rd && m_idles < need);
    chk(tag, "req_ready", req_ready, e_ready);
    @(posedge clk);
    if (v && e_ready) begin
      e_ld_n = 0; e_rd = !w; e_addr = a; m_last_rd = !w; m_idles = 0;
    end else begin
      e_ld_n = 1;
      if (m_idles < 3) m_idles++;
    end
    @(negedge clk);
    chk(tag, "cmd_ld_n", cmd_ld_n, e_ld_n);
    chk(tag, "cmd_rd", cmd_rd, e_rd);
    chk(tag, "cmd_addr", cmd_addr, e_addr);
    // observed spacing, independent of the model state
    if (!cmd_ld_n && !cmd_rd) chk(tag, "idles before write", (obs_gap >= need), 1);
    if (!cmd_ld_n && cmd_rd) obs_gap = 0;
    else if (obs_gap < 99) obs_gap++;
  endtask

  // offer a request until accepted; returns the number of stalled cycles
  task automatic push(input bit w, input logic [AW-1:0] a, input string tag, output int stalls);
    stalls = 0;
    for (int k = 0; k < 10; k++) begin
      cyc(1, w, a, tag);
      if (e_ready) break;
      stalls++;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int st;
    @(negedge clk);
    // R1: reset values
    chk("R1", "cmd_ld_n", cmd_ld_n, 1);
    chk("R1", "cmd_rd", cmd_rd, 1);
    chk("R1", "cmd_addr", cmd_addr, 0);
    chk("R1", "req_ready", req_ready, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(1, "R1");

    // R2 / R3: back-to-back reads
    for (int i = 0; i < 6; i++) cyc(1, 0, AW'(20'h100 + i), "R3");
    idle(1, "R9");
    // R2 / R4: back-to-back writes then an immediate read
    for (int i = 0; i < 5; i++) cyc(1, 1, AW'(20'h200 + i), "R4");
    push(0, 20'h300, "R4", st); chk("R4", "read stalls after write", st, 0);
    cyc(1, 0, 20'h301, "R3");

    // R5: read then write, two idles
    push(1, 20'h4A5A5, "R5", st); chk("R5", "write stalls", st, 2);
    idle(4, "R9");

    // R6: three idles
    cfg_extra_idle = 1'b1;
    cyc(1, 0, 20'h500, "R6");
    push(1, 20'h5BEEF, "R6", st); chk("R6", "write stalls", st, 3);
    // R8: read during window not held back; write after it waits again
    cyc(1, 0, 20'h510, "R8");
    cyc(1, 0, 20'h511, "R8");
    push(1, 20'h5CAFE, "R8", st); chk("R8", "write stalls", st, 3);
    idle(4, "R9");

    // R7: request-stream idles count toward gap
    cyc(1, 0, 20'h600, "R7");
    idle(3, "R7");
    push(1, 20'h601, "R7", st); chk("R7", "write stalls after 3 idles", st, 0);
    cyc(1, 0, 20'h602, "R7");
    idle(1, "R7");
    push(1, 20'h603, "R7", st); chk("R7", "write stalls after 1 idle", st, 2);
    cfg_extra_idle = 1'b0;
    idle(4, "R9");
    cyc(1, 0, 20'h700, "R7");
    idle(1, "R7");
    push(1, 20'h701, "R7", st); chk("R7", "write stalls cfg0 after 1 idle", st, 1);

    // mixed pattern
    for (int i = 0; i < 20; i++) begin
      if (i % 5 == 3) idle(1, "R9");
      else push(((i * 7) % 3) == 0, AW'(20'h800 + i * 3), "R2", st);
    end
    idle(3, "R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule